// File: doc/BRIEF.md
# Programmable-Rate Countdown Timer

An 8-bit down-counter with a byte-wide register port and an active-low interrupt output. A free-running prescaler chain, driven by a single-cycle base enable (nominally 4096 Hz), derives three slower enables: base/64, base/4096 and a further divide-by-60 of the last. A two-bit field picks one of the four as the counting clock. While the timer is enabled, each selected tick moves the counter one step toward zero. Reaching zero raises a sticky flag and reloads the counter from the programmed start value.

The interrupt output has two behaviours, chosen by a mode bit. In level mode it stays low while the flag and the interrupt enable are both set. In pulse mode it drops low for one source-tick interval after each expiry, whatever the flag is doing. Software clears the flag by writing it as zero. Writing the start value also loads the counter on the same edge, and a start value of zero stops expiries altogether.

Top module: `rtc_countdown_timer`

## Requirements
- R1: After reset every register reads 0x00 and `irq_no` is high.
- R2: The timer-control register is at address 0xE. Bit 7 enables counting. Bits 1:0 select the source: 0 = base enable, 1 = base/DIV_FAST, 2 = that /DIV_SLOW, 3 = that /DIV_MIN.
- R3: The prescaler stages run freely from reset whether or not the timer is enabled. Each stage emits a tick on every DIV-th tick of the stage below it, the first one on the DIV-th tick after reset.
- R4: The count register at 0xF reads the live counter. On a selected tick while enabled, a counter above 1 decrements. While disabled it holds its value.
- R5: A selected tick while enabled, with the counter at 1, sets the timer flag and reloads the counter from the start value. With start value N, expiries therefore come every N ticks.
- R6: Writing 0xF sets the start value and the counter on the same edge; this write takes priority over a decrement or reload on that edge. With a start value of 0 the counter stays at 0 and never expires.
- R7: Control 2 is at 0x1, with bit 0 the interrupt enable, bit 2 the timer flag and bit 4 the pulse-mode select. Writing bit 2 as 0 clears the flag, and writing it as 1 has no effect. An expiry on the same edge as a clear leaves the flag set.
- R8: With bit 4 of control 2 at 0, `irq_no` is low exactly while the flag and the interrupt enable are both 1.
- R9: With bit 4 at 1, `irq_no` goes low on the edge of an expiry (if the interrupt enable is 1) and returns high on the next selected tick that is not itself an expiry. The flag still sets as in R5.
- R10: Unused bits and unmapped addresses read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_tick_i | input | 1 | Single-cycle base-rate enable |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_no | output | 1 | Timer interrupt, active low |

## Verification
A wrong counter value shows up on the count register read in the very next cycle. It then shifts every later expiry, so the flag and `irq_no` fall out of step with the reference within one reload period. A prescaler phase error only becomes visible on the first tick of the affected source, which for the slowest source can be DIV_FAST*DIV_SLOW*DIV_MIN base ticks later. That is why the bench uses small divide ratios. A wrong pulse or flag bit changes `irq_no` in the cycle after the edge that set it.

// File: rtl/rtc_timer_pkg.sv
package rtc_timer_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_CTRL2  = 4'h1;
  localparam logic [ADDR_W-1:0] ADDR_TCTRL  = 4'hE;
  localparam logic [ADDR_W-1:0] ADDR_TCOUNT = 4'hF;

  localparam int BIT_TIE   = 0;
  localparam int BIT_TF    = 2;
  localparam int BIT_PULSE = 4;
  localparam int BIT_TEN   = 7;

  typedef enum logic [1:0] {
    SRC_BASE = 2'd0,
    SRC_FAST = 2'd1,
    SRC_SLOW = 2'd2,
    SRC_MIN  = 2'd3
  } src_sel_e;
endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen
  import rtc_timer_pkg::*;
#(
  parameter int DIV_FAST = 64,
  parameter int DIV_SLOW = 64,
  parameter int DIV_MIN  = 60
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     base_tick_i,
  input  src_sel_e sel_i,
  output logic     src_tick_o
);
  localparam int NSTAGE = 3;
  localparam int MAXD01 = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
  localparam int MAXD   = (MAXD01 > DIV_MIN) ? MAXD01 : DIV_MIN;
  localparam int CW     = (MAXD > 2) ? $clog2(MAXD) : 1;
  localparam int DIVS [NSTAGE] = '{DIV_FAST, DIV_SLOW, DIV_MIN};

  logic [NSTAGE:0] stage_tick;
  assign stage_tick[0] = base_tick_i;

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    logic [CW-1:0] pre_q;
    logic          wrap;
    assign wrap = (pre_q == CW'(DIVS[g] - 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            pre_q <= '0;
      else if (stage_tick[g]) pre_q <= wrap ? '0 : pre_q + 1'b1;
    end
    assign stage_tick[g+1] = stage_tick[g] & wrap;
  end

  assign src_tick_o = stage_tick[sel_i];
endmodule

// File: rtl/rtc_down_counter.sv
module rtc_down_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, reload_q;
  logic             step;

  assign step     = en_i & tick_i;
  assign expire_o = step & (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (load_i) begin
      cnt_q    <= load_val_i;
      reload_q <= load_val_i;
    end else if (expire_o) begin
      cnt_q <= reload_q;
    end else if (step && cnt_q > CNT_W'(1)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/rtc_timer_regs.sv
module rtc_timer_regs
  import rtc_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              expire_i,
  input  logic [DATA_W-1:0] cnt_i,
  output logic              en_o,
  output src_sel_e          sel_o,
  output logic              tie_o,
  output logic              flag_o,
  output logic              pulse_mode_o,
  output logic              load_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic wr_ctrl2, wr_tctrl;

  assign wr_ctrl2 = we_i && (addr_i == ADDR_CTRL2);
  assign wr_tctrl = we_i && (addr_i == ADDR_TCTRL);
  assign load_o   = we_i && (addr_i == ADDR_TCOUNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o         <= 1'b0;
      sel_o        <= SRC_BASE;
      tie_o        <= 1'b0;
      pulse_mode_o <= 1'b0;
      flag_o       <= 1'b0;
    end else begin
      if (wr_tctrl) begin
        en_o  <= wdata_i[BIT_TEN];
        sel_o <= src_sel_e'(wdata_i[1:0]);
      end
      if (wr_ctrl2) begin
        tie_o        <= wdata_i[BIT_TIE];
        pulse_mode_o <= wdata_i[BIT_PULSE];
      end
      // expiry wins over a same-edge clear
      if (expire_i)                          flag_o <= 1'b1;
      else if (wr_ctrl2 && !wdata_i[BIT_TF]) flag_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL2: begin
        rdata_o[BIT_TIE]   = tie_o;
        rdata_o[BIT_TF]    = flag_o;
        rdata_o[BIT_PULSE] = pulse_mode_o;
      end
      ADDR_TCTRL: begin
        rdata_o[BIT_TEN] = en_o;
        rdata_o[1:0]     = sel_o;
      end
      ADDR_TCOUNT: rdata_o = cnt_i;
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_timer_irq.sv
module rtc_timer_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic src_tick_i,
  input  logic flag_i,
  input  logic tie_i,
  input  logic pulse_mode_i,
  output logic irq_no
);
  logic pulse_q;

  // held from an expiry until the next non-expiring source tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pulse_q <= 1'b0;
    else if (expire_i)   pulse_q <= 1'b1;
    else if (src_tick_i) pulse_q <= 1'b0;
  end

  assign irq_no = pulse_mode_i ? ~(pulse_q & tie_i) : ~(flag_i & tie_i);
endmodule

// File: rtl/rtc_countdown_timer.sv
module rtc_countdown_timer
  import rtc_timer_pkg::*;
#(
  parameter int DIV_FAST = 64,
  parameter int DIV_SLOW = 64,
  parameter int DIV_MIN  = 60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_no
);
  src_sel_e          sel_w;
  logic              src_tick_w, en_w, tie_w, flag_w, pulse_mode_w, load_w, expire_w;
  logic [DATA_W-1:0] cnt_w, reload_w;

  rtc_tick_gen #(
    .DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW), .DIV_MIN(DIV_MIN)
  ) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .base_tick_i(base_tick_i),
    .sel_i(sel_w), .src_tick_o(src_tick_w)
  );

  rtc_down_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_w), .tick_i(src_tick_w),
    .load_i(load_w), .load_val_i(wdata_i),
    .cnt_o(cnt_w), .reload_o(reload_w), .expire_o(expire_w)
  );

  rtc_timer_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .expire_i(expire_w), .cnt_i(cnt_w),
    .en_o(en_w), .sel_o(sel_w), .tie_o(tie_w), .flag_o(flag_w),
    .pulse_mode_o(pulse_mode_w), .load_o(load_w), .rdata_o(rdata_o)
  );

  rtc_timer_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .expire_i(expire_w),
    .src_tick_i(src_tick_w), .flag_i(flag_w), .tie_i(tie_w),
    .pulse_mode_i(pulse_mode_w), .irq_no(irq_no)
  );
endmodule

// File: rtl/rtc_countdown_timer_chk.sv
module rtc_countdown_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en,
  input logic             src_tick,
  input logic             load,
  input logic             expire,
  input logic             flag,
  input logic             tie,
  input logic             pulse_mode,
  input logic             irq_no,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload
);
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !load) |=> $stable(cnt));

  assert_decrement_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && src_tick && !load && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - 1'b1));

  assert_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !load) |=> (cnt == $past(reload)));

  assert_flag_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> flag);

  assert_zero_silent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0) |-> !expire);

  assert_level_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_mode && !flag) |-> irq_no);

  assert_pulse_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_mode && tie && expire) |=> (pulse_mode && tie) |-> !irq_no);
endmodule

bind rtc_countdown_timer rtc_countdown_timer_chk #(.CNT_W(rtc_timer_pkg::DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en(en_w), .src_tick(src_tick_w),
  .load(load_w), .expire(expire_w), .flag(flag_w), .tie(tie_w),
  .pulse_mode(pulse_mode_w), .irq_no(irq_no), .cnt(cnt_w), .reload(reload_w)
);

// File: tb/rtc_countdown_timer_test.sv
module rtc_countdown_timer_test;
  localparam int D1 = 4;
  localparam int D2 = 4;
  localparam int D3 = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       base_tick_i = 1'b0;
  logic       we_i = 1'b0;
  logic [3:0] addr_i = 4'h0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       irq_no;

  always #4 clk_i = ~clk_i;

  rtc_countdown_timer #(.DIV_FAST(D1), .DIV_SLOW(D2), .DIV_MIN(D3)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .base_tick_i(base_tick_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_no(irq_no)
  );

  int checks = 0;
  int failures = 0;
  int gap = 1;
  int cyc = 0;

  // behavioural reference state
  int p1, p2, p3, m_sel, m_cnt, m_rel;
  bit m_en, m_flag, m_tie, m_mode, m_pulse;
  bit t64, t1, tm, src, ex;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1 = 0; p2 = 0; p3 = 0; m_sel = 0; m_cnt = 0; m_rel = 0;
      m_en = 0; m_flag = 0; m_tie = 0; m_mode = 0; m_pulse = 0;
    end else begin
      t64 = base_tick_i && (p1 == D1 - 1);
      t1  = t64 && (p2 == D2 - 1);
      tm  = t1 && (p3 == D3 - 1);
      case (m_sel)
        0: src = base_tick_i;
        1: src = t64;
        2: src = t1;
        default: src = tm;
      endcase
      ex = m_en && src && (m_cnt == 1);
      if (base_tick_i) p1 = (p1 + 1) % D1;
      if (t64) p2 = (p2 + 1) % D2;
      if (t1) p3 = (p3 + 1) % D3;
      if (ex) m_pulse = 1; else if (src) m_pulse = 0;
      if (ex) m_flag = 1;
      else if (we_i && addr_i == 4'h1 && !wdata_i[2]) m_flag = 0;
      if (we_i && addr_i == 4'hF) begin m_cnt = wdata_i; m_rel = wdata_i; end
      else if (ex) m_cnt = m_rel;
      else if (m_en && src && m_cnt > 1) m_cnt = m_cnt - 1;
      if (we_i && addr_i == 4'hE) begin m_en = wdata_i[7]; m_sel = wdata_i[1:0]; end
      if (we_i && addr_i == 4'h1) begin m_tie = wdata_i[0]; m_mode = wdata_i[4]; end
    end
  end

  function automatic int exp_rdata(logic [3:0] a);
    case (a)
      4'h1: return {m_mode, 1'b0, m_flag, 1'b0, m_tie};
      4'hE: return {m_en, 5'b0, m_sel[1:0]};
      4'hF: return m_cnt;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_outputs();
    string t;
    chk(m_mode ? "R9 irq" : "R8 irq", irq_no, !((m_mode ? m_pulse : m_flag) && m_tie));
    case (addr_i)
      4'h1: t = "R7 ctrl2";
      4'hE: t = "R2 tctrl";
      4'hF: t = "R4 count";
      default: t = "R10 unmapped";
    endcase
    chk(t, rdata_o, exp_rdata(addr_i));
  endtask

  task automatic step(input bit we, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    compare_outputs();
    we_i = we; addr_i = a; wdata_i = d;
    base_tick_i = ((cyc % gap) == 0);
    cyc++;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    step(1'b1, a, d);
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    step(1'b0, a, 8'h00);
    #1 v = rdata_o;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      case (i % 3)
        0: step(1'b0, 4'hF, 8'h00);
        1: step(1'b0, 4'h1, 8'h00);
        default: step(1'b0, 4'hE, 8'h00);
      endcase
    end
  endtask

  initial begin : watchdog
    #1200000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int v, v2;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1
    chk("R1 irq idle", irq_no, 1);
    rd(4'h1, v); chk("R1 ctrl2", v, 0);
    rd(4'hE, v); chk("R1 tctrl", v, 0);
    rd(4'hF, v); chk("R1 count", v, 0);

    // R2 R4 R5 R8: base source, start value 5, level mode
    gap = 1;
    wr(4'hF, 8'd5); wr(4'h1, 8'h01); wr(4'hE, 8'h80);
    idle(40);
    wr(4'hE, 8'h00);
    rd(4'h1, v); chk("R5 flag set", v, 8'h05);
    chk("R8 irq low", irq_no, 0);
    wr(4'h1, 8'h05);
    rd(4'h1, v); chk("R7 write one keeps flag", v, 8'h05);
    wr(4'h1, 8'h01);
    rd(4'h1, v); chk("R7 clear flag", v, 8'h01);
    chk("R8 irq high", irq_no, 1);
    rd(4'hF, v); idle(10); rd(4'hF, v2);
    chk("R4 hold when disabled", v2, v);

    // R3: slower sources
    gap = 2;
    wr(4'hF, 8'd2); wr(4'hE, 8'h81); idle(60);
    wr(4'hE, 8'h82); idle(150);
    wr(4'hE, 8'h00); wr(4'h1, 8'h01); wr(4'hF, 8'd2); wr(4'hE, 8'h83);
    idle(40);
    rd(4'h1, v); chk("R3 slowest source not yet expired", v, 8'h01);
    idle(250);
    rd(4'h1, v); chk("R3 slowest source expired", v, 8'h05);
    wr(4'hE, 8'h00);

    // R9: pulse mode
    gap = 3;
    wr(4'h1, 8'h11); wr(4'hF, 8'd3); wr(4'hE, 8'h80);
    idle(80);
    rd(4'h1, v); chk("R9 flag in pulse mode", v, 8'h15);
    wr(4'hE, 8'h00);

    // R6: zero start value, immediate load
    gap = 1;
    wr(4'h1, 8'h01); wr(4'hF, 8'd0); wr(4'hE, 8'h80);
    idle(50);
    rd(4'h1, v); chk("R6 zero never expires", v, 8'h01);
    rd(4'hF, v); chk("R6 zero count stays", v, 0);
    wr(4'hF, 8'd9);
    rd(4'hF, v); chk("R6 immediate load", v, 9);
    idle(30);
    wr(4'hE, 8'h00);

    // R10
    wr(4'h5, 8'hFF);
    rd(4'h5, v); chk("R10 unmapped read", v, 0);
    rd(4'h1, v); chk("R10 ctrl2 untouched", v, exp_rdata(4'h1));
    wr(4'hE, 8'h7C);
    rd(4'hE, v); chk("R10 unused tctrl bits", v, 0);
    idle(6);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule